// File: doc/BRIEF.md
# Dual-Mode Double-Buffered SPI Controller

This block is an SPI port that works either as the bus master or as a slave, picked by one control bit. Software-side logic writes a word into a transmit holding register and collects finished words from a receive holding register. A single shift register moves the bits, and its word length can be set from 1 to 8 bits. When a word finishes, the received bits move to the receive holding register on their own. If a new word is already waiting, it drops into the shift register so that the next word follows with no idle clock.

As master, the block makes SCK from the system clock through a programmable divider, using SPI mode 0. It holds its select line low for as long as words keep chaining. It starts a word only when the attached slave shows it is ready on a handshake input whose polarity can be set. As slave, it brings the external select, clock and data into the system clock domain. It flags a frame that the master cuts short. Two interrupt lines come out: one for an empty transmit holding register, and one shared by receive-ready and the two error flags.

Top module: `spi_duplex`

## Requirements
- R1: After reset, `status` reads 0x20 (bit 5 transmit-empty set, all else clear), `rx_rdata` is 0, `ss_n_o` is high, `sck_o` is low and both interrupt lines are low.
- R2: In master mode (control bit 7 = 1), a word of N bits (control bits [2:0] = N-1) is sent MSB first on `mosi_o`, taking bits [N-1:0] of the written word. SCK idles low, `mosi_o` changes only on SCK falling edges, and `miso_i` is sampled on rising edges. The received word lands in `rx_rdata` bits [N-1:0] with the upper bits zero, and receive-ready (status bit 6) sets.
- R3: The master starts a word only while the transmit holding register is full and the ready input is active. The ready input is active high when control bit 3 is 0 and active low when it is 1.
- R4: The master holds `ss_n_o` low from the start of a word until the last chained word ends. If new data is written before a word ends, the next word follows on the next SCK period with `ss_n_o` staying low, and SCK stays low whenever `ss_n_o` is high.
- R5: Transmit-empty (status bit 5) sets when the shift register loads from the holding register and clears on a write of `tx_wdata`. `irq_txe` equals transmit-empty gated by control bit 4.
- R6: A read pulse on `rx_rd` clears receive-ready.
- R7: In master mode, a word that completes while receive-ready is set overwrites `rx_rdata` and sets the overrun flag (status bit 1).
- R8: In slave mode, a falling `ss_n_i` loads the shift register from a full holding register. Bits are then taken from `mosi_i` on SCK rising edges and shifted out MSB first on `miso_o` on falling edges, and N received bits complete a word.
- R9: In slave mode, a word that completes while receive-ready is set leaves `rx_rdata` unchanged and sets the overrun flag.
- R10: In slave mode, if `ss_n_i` rises with a partial word in the shift register, the exchange ends and the bit-count error flag (status bit 0) sets. This flag never sets in master mode.
- R11: A pulse on `err_clr` bit 0 clears the bit-count error flag, and a pulse on bit 1 clears the overrun flag.
- R12: `irq_rx` is high when receive-ready is set with control bit 6 = 1, or when either error flag is set with control bit 5 = 1.
- R13: In slave mode the ready input has no effect: a slave exchange completes while the ready input is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_div | input | DIV_W | Master SCK half period minus one, in system clocks |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control value: [7] master, [6] rx irq en, [5] error irq en, [4] tx-empty irq en, [3] ready invert, [2:0] bits-1 |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | DATA_W | Word to transmit |
| rx_rd | input | 1 | Read pulse, clears receive-ready |
| rx_rdata | output | DATA_W | Receive holding register |
| err_clr | input | 2 | Clear pulses: [0] bit-count error, [1] overrun |
| status | output | 8 | [6] rx ready, [5] tx empty, [1] overrun, [0] bit-count error |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-ready / error interrupt |
| drdy_i | input | 1 | Slave-ready handshake (master mode) |
| sck_o | output | 1 | SCK driven in master mode |
| sck_i | input | 1 | SCK received in slave mode |
| ss_n_o | output | 1 | Select driven in master mode |
| ss_n_i | input | 1 | Select received in slave mode |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_i | input | 1 | Master data in |

## Verification
The master path runs through a table of word lengths (1, 3, 4, 5 and 8 bits) with patterns that put a lone one at the MSB or the LSB, or leave junk above the word. This separates MSB-first order, correct bit counting and masking of the unused upper bits. A two-word chain with a 16-bit reply tells a gapless reload from a restart, because the SCK edges are counted while select stays low. The same chain makes the second word overwrite an unread first one. In slave mode, full 8-bit and 4-bit frames, a frame into an unread receive register, and a frame cut after three bits show how the slave keeps old data and detects a short frame where the master would not.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
    // control register bit positions
    localparam int C_MASTER = 7;
    localparam int C_RXIE   = 6;
    localparam int C_ERIE   = 5;
    localparam int C_TXIE   = 4;
    localparam int C_RDYINV = 3;
    // status register bit positions
    localparam int S_BERR   = 0;
    localparam int S_OVR    = 1;
    localparam int S_TXE    = 5;
    localparam int S_RXR    = 6;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          W   = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST[i];
                sync_q <= RST[i];
            end else begin
                meta_q <= d[i];
                sync_q <= meta_q;
            end
        end
        assign q[i] = sync_q;
    end
endmodule

// File: rtl/spi_tick.sv
module spi_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == div);
        cnt_d = (clr || tick) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_duplex.sv
module spi_duplex
    import spi_duplex_pkg::*;
#(
    parameter int DATA_W = 8,   // word length limit; field [2:0] assumes 8
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  sclk_div,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic [1:0]        err_clr,
    output logic [7:0]        status,
    output logic              irq_txe,
    output logic              irq_rx,
    input  logic              drdy_i,
    output logic              sck_o,
    input  logic              sck_i,
    output logic              ss_n_o,
    input  logic              ss_n_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              miso_i
);
    localparam int LEN_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [7:0]        ctrl;
        logic [DATA_W-1:0] txb;
        logic [DATA_W-1:0] rxb;
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              txe;
        logic              rxr;
        logic              ovr;
        logic              berr;
        logic              act;
        logic              sck;
        logic              bit_in;
        logic              ss_p;
        logic              sck_p;
    } st_t;

    st_t d, q;
    logic ss_s, sck_s, mosi_s, tick, tick_clr, master;
    logic [CNT_W-1:0]  nbits, cnt_nx;
    logic [DATA_W-1:0] mask, sr_shift;
    logic [LEN_W-1:0]  top_idx;
    logic load, word_done, rx_busy;

    spi_sync #(.W(3), .RST(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({mosi_i, sck_i, ss_n_i}),
        .q({mosi_s, sck_s, ss_s})
    );

    spi_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .div(sclk_div), .tick(tick)
    );

    always_comb begin
        d         = q;
        load      = 1'b0;
        word_done = 1'b0;
        tick_clr  = 1'b0;
        master    = q.ctrl[C_MASTER];
        top_idx   = q.ctrl[LEN_W-1:0];
        nbits     = CNT_W'(top_idx) + CNT_W'(1);
        cnt_nx    = q.cnt + CNT_W'(1);
        mask      = (DATA_W'(1) << nbits) - DATA_W'(1);
        sr_shift  = {q.sr[DATA_W-2:0], q.bit_in};
        rx_busy   = q.rxr & ~rx_rd;

        if (ctrl_wr)    d.ctrl = ctrl_wdata;
        if (err_clr[0]) d.berr = 1'b0;
        if (err_clr[1]) d.ovr  = 1'b0;
        if (rx_rd)      d.rxr  = 1'b0;
        d.ss_p  = ss_s;
        d.sck_p = sck_s;

        if (master) begin
            if (!q.act) begin
                if (!q.txe && (drdy_i ^ q.ctrl[C_RDYINV])) begin
                    d.act    = 1'b1;
                    d.sck    = 1'b0;
                    d.cnt    = '0;
                    load     = 1'b1;
                    tick_clr = 1'b1;
                end
            end else if (tick) begin
                if (!q.sck) begin
                    d.sck    = 1'b1;
                    d.bit_in = miso_i;
                end else begin
                    d.sck = 1'b0;
                    d.sr  = sr_shift;
                    d.cnt = cnt_nx;
                    if (cnt_nx == nbits) begin
                        word_done = 1'b1;
                        d.cnt     = '0;
                        if (!q.txe) load = 1'b1;
                        else        d.act = 1'b0;
                    end
                end
            end
        end else begin
            d.sck = 1'b0;
            if (q.ss_p && !ss_s) begin
                d.act = 1'b1;
                d.cnt = '0;
                if (!q.txe) load = 1'b1;
            end else if (q.act) begin
                if (!q.ss_p && ss_s) begin
                    d.act = 1'b0;
                    if (q.cnt != '0) d.berr = 1'b1;
                end else if (!q.sck_p && sck_s) begin
                    d.bit_in = mosi_s;
                end else if (q.sck_p && !sck_s) begin
                    d.sr  = sr_shift;
                    d.cnt = cnt_nx;
                    if (cnt_nx == nbits) begin
                        word_done = 1'b1;
                        d.cnt     = '0;
                        if (!q.txe) load = 1'b1;
                    end
                end
            end
        end

        if (load) begin
            d.sr  = q.txb;
            d.txe = 1'b1;
        end
        if (word_done) begin
            if (rx_busy) d.ovr = 1'b1;
            if (master || !rx_busy) begin
                d.rxb = sr_shift & mask;
                d.rxr = 1'b1;
            end
        end
        if (tx_wr) begin
            d.txb = tx_wdata;
            d.txe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.txe  <= 1'b1;
            q.ss_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_rdata = q.rxb;
    assign status   = {1'b0, q.rxr, q.txe, 3'b000, q.ovr, q.berr};
    assign irq_txe  = q.txe & q.ctrl[C_TXIE];
    assign irq_rx   = (q.rxr & q.ctrl[C_RXIE]) | ((q.ovr | q.berr) & q.ctrl[C_ERIE]);
    assign sck_o    = master & q.sck;
    assign ss_n_o   = ~(master & q.act);
    assign mosi_o   = master & q.sr[top_idx];
    assign miso_o   = ~master & q.sr[top_idx];
endmodule

// File: rtl/spi_duplex_chk.sv
module spi_duplex_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode,
    input logic          sck_o,
    input logic          ss_n_o,
    input logic          mosi_o,
    input logic          tx_wr,
    input logic          rx_rd,
    input logic [7:0]    status,
    input logic [DW-1:0] rx_rdata
);
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sck_o); // R4

    AST_MOSI_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && $past(mode) && sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R2

    AST_TXE_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !status[5]); // R5

    AST_BERR_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> !$past(mode)); // R10

    AST_SLAVE_RX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !$past(mode) && !$past(rx_rd) && $past(status[6]) && status[6])
        |-> $stable(rx_rdata)); // R9
endmodule

bind spi_duplex spi_duplex_chk #(.DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(master), .sck_o(sck_o), .ss_n_o(ss_n_o),
    .mosi_o(mosi_o), .tx_wr(tx_wr), .rx_rd(rx_rd), .status(status),
    .rx_rdata(rx_rdata)
);

// File: tb/spi_duplex_bench.sv
`timescale 1ns/1ps
module spi_duplex_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] sclk_div = 8'd3;
    logic ctrl_wr = 0, tx_wr = 0, rx_rd = 0;
    logic [7:0] ctrl_wdata = 0, tx_wdata = 0;
    logic [1:0] err_clr = 0;
    logic drdy_i = 1'b1, sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_i;
    logic [7:0] rx_rdata, status;
    logic irq_txe, irq_rx, sck_o, ss_n_o, mosi_o, miso_o;

    int nchk = 0, nerr = 0;
    logic [15:0] sl_word = 0, cap = 0;
    int sl_idx = -1, sck_rises = 0;

    always #2 clk = ~clk;

    spi_duplex u_spi_duplex (.*);

    // bench-side slave seen by the master
    assign miso_i = (sl_idx >= 0) ? sl_word[sl_idx[3:0]] : 1'b0;
    always @(posedge sck_o) begin
        cap = {cap[14:0], mosi_o};
        sck_rises++;
    end
    always @(negedge sck_o) sl_idx = sl_idx - 1;

    task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask
    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wdata = v; ctrl_wr = 1; cyc(1); ctrl_wr = 0; cyc(1);
    endtask
    task automatic wr_tx(input logic [7:0] v);
        tx_wdata = v; tx_wr = 1; cyc(1); tx_wr = 0;
    endtask
    task automatic rd_rx(); rx_rd = 1; cyc(1); rx_rd = 0; cyc(1); endtask
    task automatic clr_err(input logic [1:0] v); err_clr = v; cyc(1); err_clr = 0; cyc(1); endtask
    task automatic wait_bit(input int b, input logic v);
        for (int i = 0; i < 2000 && status[b] !== v; i++) cyc(1);
    endtask
    task automatic slave_frame(input int nb, input logic [7:0] mo, input int send,
                               output logic [7:0] mi);
        mi = 0; ss_n_i = 0; cyc(10);
        for (int i = 0; i < send; i++) begin
            mosi_i = mo[nb-1-i]; cyc(6);
            mi = {mi[6:0], miso_o};
            sck_i = 1; cyc(6); sck_i = 0; cyc(6);
        end
        ss_n_i = 1; cyc(10);
    endtask

    // {bits, tx word, slave reply}
    localparam logic [23:0] VEC [0:5] = '{
        {8'd8, 8'hA5, 8'h3C}, {8'd8, 8'h01, 8'h80}, {8'd5, 8'h13, 8'h0A},
        {8'd1, 8'h01, 8'h01}, {8'd3, 8'h06, 8'h05}, {8'd4, 8'hF3, 8'h0E}};

    initial begin
        #600000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] mi, msk;
        cyc(3); rst_n = 1; cyc(2);
        chk("R1 status", status, 8'h20);
        chk("R1 rx", rx_rdata, 8'h00);
        chk("R1 pins", {ss_n_o, sck_o, irq_txe, irq_rx}, 4'b1000);

        // master table: lengths, bit order, masking
        for (int v = 0; v < 6; v++) begin
            int nb;
            nb  = int'(VEC[v][23:16]);
            msk = 8'((16'd1 << nb) - 1);
            wr_ctrl(8'h80 | 8'(nb - 1));
            sl_word = {8'h00, VEC[v][7:0]}; sl_idx = nb - 1; cap = 0;
            wr_tx(VEC[v][15:8]);
            wait_bit(6, 1'b1); cyc(1);
            chk("R2 rx word", rx_rdata, VEC[v][7:0] & msk);
            chk("R2 mosi word", cap, {8'h00, VEC[v][15:8] & msk});
            chk("R4 ss released", ss_n_o, 1'b1);
            chk("R5 txe after load", status[5], 1'b1);
            rd_rx();
            chk("R6 rx ready cleared", status[6], 1'b0);
        end
        chk("R10 no berr in master", status[0], 1'b0);

        // ready gating and polarity
        wr_ctrl(8'h87); drdy_i = 0;
        sl_word = 16'h00C3; sl_idx = 7;
        wr_tx(8'h55); cyc(40);
        chk("R3 held by ready", {ss_n_o, status[5]}, 2'b10);
        wr_ctrl(8'h8F);
        wait_bit(6, 1'b1); cyc(1);
        chk("R3 inverted ready start", rx_rdata, 8'hC3);
        rd_rx();

        // gapless chain and master overrun
        wr_ctrl(8'h87); drdy_i = 1;
        sl_word = 16'hC35A; sl_idx = 15; cap = 0; sck_rises = 0;
        wr_tx(8'h96); wait_bit(5, 1'b1); wr_tx(8'h3B);
        for (int i = 0; i < 2000 && ss_n_o !== 1'b1; i++) cyc(1);
        chk("R4 one select window", sck_rises, 16);
        chk("R4 chained bits", cap, 16'h963B);
        chk("R7 overwrite", rx_rdata, 8'h5A);
        chk("R7 overrun flag", status[1], 1'b1);
        chk("R12 masked", irq_rx, 1'b0);
        wr_ctrl(8'hA7);
        chk("R12 error irq", irq_rx, 1'b1);
        clr_err(2'b10);
        chk("R11 overrun cleared", status[1], 1'b0);
        chk("R12 error irq gone", irq_rx, 1'b0);
        wr_ctrl(8'hC7);
        chk("R12 rx irq", irq_rx, 1'b1);
        rd_rx();
        chk("R12 rx irq gone", irq_rx, 1'b0);

        // transmit-empty interrupt
        drdy_i = 0;
        wr_ctrl(8'h97);
        chk("R5 irq_txe set", irq_txe, 1'b1);
        wr_tx(8'hC6); cyc(1);
        chk("R5 irq_txe clear", {irq_txe, status[5]}, 2'b00);

        // slave mode, ready input inactive throughout
        wr_ctrl(8'h07); cyc(4);
        slave_frame(8, 8'h69, 8, mi);
        chk("R8 miso word", mi, 8'hC6);
        chk("R13 slave rx with ready low", rx_rdata, 8'h69);
        chk("R8 flags", {status[6], status[5], status[0]}, 3'b110);
        slave_frame(8, 8'h12, 8, mi);
        chk("R9 old data kept", rx_rdata, 8'h69);
        chk("R9 overrun", status[1], 1'b1);
        clr_err(2'b10); rd_rx();

        wr_ctrl(8'h27);
        slave_frame(8, 8'hFF, 3, mi);
        chk("R10 short frame", {status[6], status[0]}, 2'b01);
        chk("R12 berr irq", irq_rx, 1'b1);
        clr_err(2'b01);
        chk("R11 berr cleared", status[0], 1'b0);

        wr_ctrl(8'h03); wr_tx(8'h0A); cyc(2);
        slave_frame(4, 8'h05, 4, mi);
        chk("R8 4-bit miso", mi & 8'h0F, 8'h0A);
        chk("R8 4-bit rx", rx_rdata, 8'h05);
        chk("R10 full 4-bit frame", status[0], 1'b0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule